// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used page translations and converts one byte-addressed virtual address per request into a physical address. The virtual page number (the bits above the page offset) is compared against every stored entry at once. On a hit, the physical address is formed from the stored physical page number with the page offset passed through unchanged. The entry's reference bit is set, and on a store its dirty bit is set as well. The response also returns the two status bits as they stood before the access. On a miss the response carries a miss-exception flag. The machine state is left untouched, so a handler can install the translation and retry the access.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on `rsp_valid` right after that edge and stays there, unchanged, until a cycle with `rsp_ready` high. While a response is held back, `req_ready` is low. This makes `req_ready = !rsp_valid || rsp_ready`, so back-pressure on the response port stalls the request port with no extra buffering.

A plain refill port writes one entry per cycle. Victim choice follows this order: an entry that already holds the same virtual page, then the lowest-numbered invalid entry, then a round-robin pointer. A one-cycle clear pulse zeroes every reference bit.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid: `rsp_valid` is 0, `req_ready` is 1, and every lookup misses until a refill installs a translation.
- R2: A request taken at edge N that hits shows `rsp_valid`=1 right after edge N with `rsp_miss`=0. `rsp_paddr` is {stored physical page number, `req_vaddr[11:0]`}.
- R3: A miss gives `rsp_miss`=1 with `rsp_paddr`, `rsp_ref` and `rsp_dirty` all 0, and changes no entry.
- R4: `rsp_ref` reports the hit entry's reference bit before the access. Every hit sets that bit to 1, and a refill writes it as 0.
- R5: A `ref_clr` pulse zeroes the reference bit of every entry and leaves dirty bits alone. A hit in the same cycle as the pulse leaves its own entry's reference bit at 1.
- R6: `rsp_dirty` reports the hit entry's dirty bit before the access. A hit with `req_store`=1 sets it, a load leaves it, and a refill writes it from `fill_dirty`.
- R7: A refill whose virtual page number equals that of a valid entry overwrites that entry in place, and the round-robin pointer does not move.
- R8: When no entry matches and at least one entry is invalid, a refill writes the lowest-numbered invalid entry, and the pointer does not move.
- R9: When all entries are valid and none matches, a refill writes the entry under the round-robin pointer. The pointer starts at 0 after reset and then steps by one, wrapping from DEPTH-1 to 0.
- R10: A refill with `fill_valid`=0 invalidates the entry it selects, so later lookups of that page miss.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. A response held with `rsp_ready`=0 keeps all response fields stable.
- R12: A lookup and a refill of the same entry in the same cycle: the lookup answers from the contents before the refill, and the refill's contents and zero reference bit win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | VA_W | Virtual byte address |
| req_store | input | 1 | Access is a store (sets dirty on hit) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PPN_W+PG_OFS_W | Physical address, 0 on a miss |
| rsp_miss | output | 1 | Miss exception request |
| rsp_ref | output | 1 | Entry reference bit before this access |
| rsp_dirty | output | 1 | Entry dirty bit before this access |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | VA_W-PG_OFS_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_valid | input | 1 | Valid bit written to the entry |
| fill_dirty | input | 1 | Initial dirty bit |
| ref_clr | input | 1 | Zero all reference bits |

## Verification
The bench builds the block with DEPTH=4 and keeps the 32-bit address, 12-bit offset and 15-bit page number defaults. With four entries, a few refills fill the table. That brings the pointer wrap, the choice between a free entry and the pointer, and in-place replacement within a short run. It also lets the bench predict which translation each refill evicts. Status bits are traced through the values reported back in each response, across clears, stores, evictions, and a lookup that collides with a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W_DEF     = 32;
  localparam int unsigned PG_OFS_W_DEF = 12;
  localparam int unsigned PPN_W_DEF    = 15;
  localparam int unsigned DEPTH_DEF    = 16;

  // Where a refill lands, in falling priority.
  typedef enum logic [1:0] {
    VSRC_MATCH = 2'd0,
    VSRC_FREE  = 2'd1,
    VSRC_RR    = 2'd2
  } vsrc_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned IDX_W = 4
) (
  input  logic [TAG_W-1:0]            key,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            valid,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  logic [DEPTH-1:0] match_vec;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match_vec[e] = valid[e] && (tags[e] == key);
  end

  always_comb begin
    hit = |match_vec;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic             fill_hit,
  input  logic [IDX_W-1:0] fill_hit_idx,
  input  logic [DEPTH-1:0] valid,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  vsrc_e            src;

  always_comb begin
    free_any = ~&valid;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (fill_hit)      src = VSRC_MATCH;
    else if (free_any) src = VSRC_FREE;
    else               src = VSRC_RR;
    case (src)
      VSRC_MATCH: victim_idx = fill_hit_idx;
      VSRC_FREE:  victim_idx = free_idx;
      default:    victim_idx = rr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_en && src == VSRC_RR) begin
      rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 15,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  logic                        wr_valid,
  input  logic                        wr_dirty,
  input  logic                        acc_en,
  input  logic [IDX_W-1:0]            acc_idx,
  input  logic                        acc_store,
  input  logic                        clr,
  output logic [DEPTH-1:0][VPN_W-1:0] vpn_arr,
  output logic [DEPTH-1:0][PPN_W-1:0] ppn_arr,
  output logic [DEPTH-1:0]            valid_vec,
  output logic [DEPTH-1:0]            ref_vec,
  output logic [DEPTH-1:0]            dirty_vec
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic wr_sel;
    logic acc_sel;
    assign wr_sel  = wr_en && (wr_idx == IDX_W'(e));
    assign acc_sel = acc_en && (acc_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_arr[e]   <= '0;
        ppn_arr[e]   <= '0;
        valid_vec[e] <= 1'b0;
        ref_vec[e]   <= 1'b0;
        dirty_vec[e] <= 1'b0;
      end else if (wr_sel) begin
        // Refill wins over a same-cycle access to this entry.
        vpn_arr[e]   <= wr_vpn;
        ppn_arr[e]   <= wr_ppn;
        valid_vec[e] <= wr_valid;
        ref_vec[e]   <= 1'b0;
        dirty_vec[e] <= wr_dirty;
      end else begin
        if (acc_sel)                 ref_vec[e] <= 1'b1;
        else if (clr)                ref_vec[e] <= 1'b0;
        if (acc_sel && acc_store)    dirty_vec[e] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W     = VA_W_DEF,
  parameter int unsigned PG_OFS_W = PG_OFS_W_DEF,
  parameter int unsigned PPN_W    = PPN_W_DEF,
  parameter int unsigned DEPTH    = DEPTH_DEF,
  localparam int unsigned VPN_W   = VA_W - PG_OFS_W,
  localparam int unsigned PA_W    = PPN_W + PG_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_miss,
  output logic             rsp_ref,
  output logic             rsp_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_valid,
  input  logic             fill_dirty,
  input  logic             ref_clr
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][VPN_W-1:0] vpn_arr;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_arr;
  logic [DEPTH-1:0]            valid_vec;
  logic [DEPTH-1:0]            ref_vec;
  logic [DEPTH-1:0]            dirty_vec;

  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             fl_hit;
  logic [IDX_W-1:0] fl_idx;
  logic [IDX_W-1:0] victim_idx;
  logic             accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  tlb_cam #(.DEPTH(DEPTH), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_lookup_cam (
    .key   (req_vaddr[VA_W-1:PG_OFS_W]),
    .tags  (vpn_arr),
    .valid (valid_vec),
    .hit   (lk_hit),
    .idx   (lk_idx)
  );

  tlb_cam #(.DEPTH(DEPTH), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_fill_cam (
    .key   (fill_vpn),
    .tags  (vpn_arr),
    .valid (valid_vec),
    .hit   (fl_hit),
    .idx   (fl_idx)
  );

  tlb_victim #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_en      (fill_en),
    .fill_hit     (fl_hit),
    .fill_hit_idx (fl_idx),
    .valid        (valid_vec),
    .victim_idx   (victim_idx)
  );

  tlb_store #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fill_en),
    .wr_idx    (victim_idx),
    .wr_vpn    (fill_vpn),
    .wr_ppn    (fill_ppn),
    .wr_valid  (fill_valid),
    .wr_dirty  (fill_dirty),
    .acc_en    (accept && lk_hit),
    .acc_idx   (lk_idx),
    .acc_store (req_store),
    .clr       (ref_clr),
    .vpn_arr   (vpn_arr),
    .ppn_arr   (ppn_arr),
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec),
    .dirty_vec (dirty_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_miss  <= 1'b0;
      rsp_ref   <= 1'b0;
      rsp_dirty <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_miss  <= !lk_hit;
      if (lk_hit) begin
        rsp_paddr <= {ppn_arr[lk_idx], req_vaddr[PG_OFS_W-1:0]};
        rsp_ref   <= ref_vec[lk_idx];
        rsp_dirty <= dirty_vec[lk_idx];
      end else begin
        rsp_paddr <= '0;
        rsp_ref   <= 1'b0;
        rsp_dirty <= 1'b0;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PG_OFS_W = 12,
  parameter int unsigned PA_W     = 27,
  parameter int unsigned DEPTH    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_miss,
  input logic             rsp_ref,
  input logic             rsp_dirty,
  input logic [DEPTH-1:0] valid_vec
);
  logic accept;
  assign accept = req_valid && req_ready;

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R11

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss)
                                   && $stable(rsp_ref) && $stable(rsp_dirty))); // R11

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_miss || rsp_paddr[PG_OFS_W-1:0] == $past(req_vaddr[PG_OFS_W-1:0]))); // R2

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_paddr == '0 && !rsp_ref && !rsp_dirty)); // R3

  AST_EMPTY_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && valid_vec == '0) |=> rsp_miss); // R1
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PG_OFS_W(PG_OFS_W), .PA_W(PA_W), .DEPTH(DEPTH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_miss  (rsp_miss),
  .rsp_ref   (rsp_ref),
  .rsp_dirty (rsp_dirty),
  .valid_vec (valid_vec)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  localparam int unsigned DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [26:0] rsp_paddr;
  logic        rsp_miss;
  logic        rsp_ref;
  logic        rsp_dirty;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [14:0] fill_ppn = '0;
  logic        fill_valid = 1'b0;
  logic        fill_dirty = 1'b0;
  logic        ref_clr = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Expected {miss, ref, dirty, paddr} and the requirement it checks.
  logic [29:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tlb_xlate #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss),
    .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_valid(fill_valid),
    .fill_dirty(fill_dirty), .ref_clr(ref_clr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Monitor: pops one expectation per completed response handshake.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "response with nothing expected", 32'd1, 32'd0);
      end else begin
        logic [29:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_miss, rsp_ref, rsp_dirty, rsp_paddr} == e, t, "response {miss,ref,dirty,pa}",
              {2'b0, rsp_miss, rsp_ref, rsp_dirty, rsp_paddr}, {2'b0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  // Driver: records the expectation, then presents the request until taken.
  task automatic send(input logic [31:0] va, input bit st, input bit miss,
                      input logic [14:0] ppn, input bit rf, input bit dt, input string tag,
                      input bit clr = 1'b0, input bit cf = 1'b0,
                      input logic [19:0] cvpn = '0, input logic [14:0] cppn = '0);
    logic [26:0] pa;
    pa = miss ? 27'd0 : {ppn, va[11:0]};
    exp_q.push_back({miss, miss ? 1'b0 : rf, miss ? 1'b0 : dt, pa});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va; req_store = st; ref_clr = clr;
    if (cf) begin
      fill_en = 1'b1; fill_vpn = cvpn; fill_ppn = cppn; fill_valid = 1'b1; fill_dirty = 1'b0;
    end
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; req_store = 1'b0; ref_clr = 1'b0; fill_en = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [14:0] ppn, input bit v, input bit d);
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_valid = v; fill_dirty = d;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #1; ref_clr = 1'b1;
    @(posedge clk); #1; ref_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    send(32'h1234_5678, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R1 empty table miss");

    // Four refills into an empty table land in entries 0..3 (R8).
    fill(20'h00010, 15'h0011, 1'b1, 1'b0);   // A -> 0
    fill(20'h00020, 15'h0022, 1'b1, 1'b1);   // B -> 1
    fill(20'h00030, 15'h0033, 1'b1, 1'b0);   // C -> 2
    fill(20'h00040, 15'h0044, 1'b1, 1'b0);   // D -> 3

    send(32'h0001_0ABC, 1'b0, 1'b0, 15'h0011, 1'b0, 1'b0, "R2 hit load A");
    send(32'h0001_0004, 1'b1, 1'b0, 15'h0011, 1'b1, 1'b0, "R4 ref set by hit");
    send(32'h0001_0FFF, 1'b0, 1'b0, 15'h0011, 1'b1, 1'b1, "R6 store sets dirty");
    send(32'h0002_0000, 1'b0, 1'b0, 15'h0022, 1'b0, 1'b1, "R6 initial dirty from refill");
    send(32'h0005_0000, 1'b1, 1'b1, 15'h0, 1'b0, 1'b0, "R3 miss");
    send(32'h0002_0010, 1'b0, 1'b0, 15'h0022, 1'b1, 1'b1, "R3 miss left state");

    pulse_clr();
    send(32'h0001_0020, 1'b0, 1'b0, 15'h0011, 1'b0, 1'b1, "R5 clear zeroes ref keeps dirty");
    send(32'h0003_0100, 1'b0, 1'b0, 15'h0033, 1'b0, 1'b0, "R5 hit with clear", 1'b1);
    send(32'h0003_0200, 1'b0, 1'b0, 15'h0033, 1'b1, 1'b0, "R5 same-cycle hit keeps ref");
    send(32'h0004_0300, 1'b0, 1'b0, 15'h0044, 1'b0, 1'b0, "R5 untouched entry D");
    send(32'h0002_0400, 1'b0, 1'b0, 15'h0022, 1'b0, 1'b1, "R5 B after clears");

    // Full table: round-robin pointer from 0.
    fill(20'h00060, 15'h0066, 1'b1, 1'b0);   // E -> 0
    send(32'h0001_0ABC, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R9 A evicted by pointer 0");
    send(32'h0006_0123, 1'b0, 1'b0, 15'h0066, 1'b0, 1'b0, "R9 E installed");
    fill(20'h00070, 15'h0077, 1'b1, 1'b0);   // F -> 1
    send(32'h0002_0000, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R9 B evicted by pointer 1");
    send(32'h0003_0FFF, 1'b0, 1'b0, 15'h0033, 1'b1, 1'b0, "R9 C survives");

    // In-place replacement, pointer stays at 2.
    fill(20'h00030, 15'h003A, 1'b1, 1'b1);
    send(32'h0003_0555, 1'b0, 1'b0, 15'h003A, 1'b0, 1'b1, "R7 in-place replace");
    fill(20'h00080, 15'h0088, 1'b1, 1'b0);   // G -> 2
    send(32'h0003_0555, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R7 pointer did not move");
    send(32'h0004_0010, 1'b0, 1'b0, 15'h0044, 1'b1, 1'b0, "R9 D survives");
    send(32'h0008_0010, 1'b0, 1'b0, 15'h0088, 1'b0, 1'b0, "R9 G installed");

    // Invalidate E (entry 0), then refill prefers the free slot.
    fill(20'h00060, 15'h0000, 1'b0, 1'b0);
    send(32'h0006_0123, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R10 invalidated entry misses");
    fill(20'h00090, 15'h0009, 1'b1, 1'b0);   // H -> 0 (free)
    send(32'h0007_0001, 1'b0, 1'b0, 15'h0077, 1'b0, 1'b0, "R8 F kept");
    send(32'h0008_0002, 1'b0, 1'b0, 15'h0088, 1'b1, 1'b0, "R8 G kept");
    send(32'h0004_0003, 1'b0, 1'b0, 15'h0044, 1'b1, 1'b0, "R8 D kept");
    send(32'h0009_0004, 1'b0, 1'b0, 15'h0009, 1'b0, 1'b0, "R8 H in free entry");
    fill(20'h000A0, 15'h000A, 1'b1, 1'b0);   // I -> 3 (pointer)
    send(32'h0004_0003, 1'b0, 1'b1, 15'h0, 1'b0, 1'b0, "R9 D evicted by pointer 3");
    send(32'h000A_0005, 1'b0, 1'b0, 15'h000A, 1'b0, 1'b0, "R9 I installed");
    send(32'h0009_0006, 1'b0, 1'b0, 15'h0009, 1'b1, 1'b0, "R4 H ref");

    // Lookup collides with refill of the same entry.
    send(32'h0009_0007, 1'b0, 1'b0, 15'h0009, 1'b1, 1'b0, "R12 old contents answered",
         1'b0, 1'b1, 20'h00090, 15'h005C);
    send(32'h0009_0008, 1'b0, 1'b0, 15'h005C, 1'b0, 1'b0, "R12 refill won");

    // Back-pressure.
    wait (exp_q.size() == 0);
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(32'h0007_0ABC, 1'b1, 1'b0, 15'h0077, 1'b1, 1'b0, "R11 held response");
    fork
      send(32'h000A_0111, 1'b0, 1'b0, 15'h000A, 1'b1, 1'b0, "R11 queued request");
    join_none
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid == 1'b1, "R11", "valid held", {31'b0, rsp_valid}, 32'd1);
      check(req_ready == 1'b0, "R11", "ready low while held", {31'b0, req_ready}, 32'd0);
      check(rsp_paddr == 27'h0077ABC, "R11", "paddr stable", {5'b0, rsp_paddr}, 32'h0077ABC);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    send(32'h0007_0000, 1'b0, 1'b0, 15'h0077, 1'b1, 1'b1, "R6 stall store set dirty");
    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule